// File: doc/BRIEF.md
# DRAM Power-Down Sequencer

This block drives the clock-enable line of a DDR2-class memory device on behalf of a memory controller. When the scheduler signals that it has nothing to issue, the sequencer waits for any read data still on its way to drain. It then drops clock-enable and reports which kind of low-power state the device is in. The kind depends on whether any bank still has a row open and on whether fast or slow exit is configured.

When the scheduler withdraws its request, or when the device has stayed down for the longest allowed time, the sequencer raises clock-enable. It forces a no-operation onto the command bus while it does so. It then keeps the command path gated until both the minimum high time and the exit latency for that mode have passed.

All timing values are cycle counts given at run time. The configuration must keep nine refresh intervals at least as long as the minimum clock-enable pulse. The controller is built around six states:

- ST_ACTIVE: normal operation.
- ST_WAIT_BURST_END: the request is pending while a read tail finishes.
- ST_PD_ENTER_HOLD: clock-enable is low and the minimum low time is running.
- ST_POWER_DOWN: the device is resting.
- ST_PD_EXIT_HOLD: clock-enable is high, no-operation is forced, and the minimum high time is running.
- ST_EXIT_LATENCY: the remaining exit latency is running.

Transitions:

- ACTIVE to WAIT_BURST_END on a request while a read tail is busy.
- ACTIVE or WAIT_BURST_END to ENTER_HOLD on a request when nothing blocks entry.
- WAIT_BURST_END back to ACTIVE when the request is dropped.
- ENTER_HOLD to POWER_DOWN, or straight to EXIT_HOLD when a wake is pending, once the low time is met.
- POWER_DOWN to EXIT_HOLD on a wake or when the residency cap is reached.
- EXIT_HOLD to EXIT_LATENCY or to ACTIVE once the high time is met.
- EXIT_LATENCY to ACTIVE.

Top module: `dram_pd_ctrl`

## Requirements
- R1: Out of reset, cke is 1, cmd_inhibit is 0, force_nop is 0 and pd_mode is 00, and the state is ST_ACTIVE.
- R2: With pd_req high in ST_ACTIVE and nothing blocking entry, cke is 0 from the next cycle. While cke is 0, force_nop and cmd_inhibit are both 1.
- R3: While mrs_busy or wr_busy is 1, cke never falls and the controller stays in ST_ACTIVE or ST_WAIT_BURST_END.
- R4: A rd_cmd pulse in cycle c keeps the read tail busy through cycle c+L, where L = cfg_al + cfg_cl + B. B is 4 when cfg_bl8 = 1 (burst of 8) and 2 when cfg_bl8 = 0 (burst of 4). cke cannot be low before cycle c+L+2.
- R5: pd_mode reads 01 (precharge) when bank_open was all zero in the entry cycle. It reads 10 (active, fast exit) when a bank is open and cfg_fast_exit = 1, and 11 (active, slow exit) when a bank is open and cfg_fast_exit = 0. It reads 00 whenever cke is 1.
- R6: cke stays 0 for at least max(cfg_tcke,1) cycles. A pd_req drop during that time is remembered and causes exit as soon as the time is met.
- R7: A pd_req drop in ST_POWER_DOWN raises cke in the next cycle. force_nop stays 1 for the first max(cfg_tcke,1) cycles of cke high.
- R8: After cke rises, cmd_inhibit stays 1 for exactly max(cfg_tcke, X, 1) cycles. X is cfg_txp after precharge, cfg_txard after fast-exit active and cfg_txards after slow-exit active power-down.
- R9: cke is never 0 for more than 9 × cfg_trefi consecutive cycles. On reaching that count the controller exits even if pd_req stays 1.
- R10: After an exit forced by the residency cap, power-down is not re-entered until pd_req has been seen at 0.
- R11: Dropping pd_req in ST_WAIT_BURST_END returns to ST_ACTIVE with cke held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req | input | 1 | Scheduler idle, power-down wanted |
| bank_open | input | NBANK | One bit per bank, 1 when a row is open |
| mrs_busy | input | 1 | Mode-register command time running |
| wr_busy | input | 1 | Write operation in progress |
| rd_cmd | input | 1 | Read command issued this cycle |
| cfg_al | input | LAT_W | Additive latency, clocks |
| cfg_cl | input | LAT_W | CAS latency, clocks |
| cfg_bl8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| cfg_fast_exit | input | 1 | 1 = fast exit for active power-down |
| cfg_tcke | input | TW | Minimum clock-enable pulse, clocks |
| cfg_txp | input | TW | Exit latency after precharge power-down |
| cfg_txard | input | TW | Exit latency after fast-exit active power-down |
| cfg_txards | input | TW | Exit latency after slow-exit active power-down |
| cfg_trefi | input | TREFI_W | Refresh interval, clocks |
| cke | output | 1 | Clock-enable to the device |
| cmd_inhibit | output | 1 | Blocks the scheduler from issuing |
| force_nop | output | 1 | Drives NOP/DESELECT on the command bus |
| pd_mode | output | 2 | 00 none, 01 precharge, 10 active fast, 11 active slow |

## Verification
The bench runs one request pattern for each bank-state and exit-speed combination. These patterns tell the three modes and their three exit latencies apart, including a latency shorter than the minimum high time. It then holds mode-register and write busy flags against a request, and issues reads with both burst lengths before a request. This separates a correctly timed read tail from an early drop. A one-cycle request shows whether a wake during the minimum low time is kept. A request held for hundreds of cycles separates the residency cap and the re-entry lockout from ordinary exit.

// File: rtl/dram_pd_pkg.sv
package dram_pd_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE         = 3'd0,
        ST_WAIT_BURST_END = 3'd1,
        ST_PD_ENTER_HOLD  = 3'd2,
        ST_POWER_DOWN     = 3'd3,
        ST_PD_EXIT_HOLD   = 3'd4,
        ST_EXIT_LATENCY   = 3'd5
    } pd_state_e;

    typedef enum logic [1:0] {
        PDM_NONE      = 2'b00,
        PDM_PRECHARGE = 2'b01,
        PDM_ACT_FAST  = 2'b10,
        PDM_ACT_SLOW  = 2'b11
    } pd_mode_e;

    // Low-power flavour chosen from bank state and exit speed at entry.
    function automatic pd_mode_e pick_mode(input logic any_open, input logic fast);
        if (!any_open) return PDM_PRECHARGE;
        return fast ? PDM_ACT_FAST : PDM_ACT_SLOW;
    endfunction

endpackage

// File: rtl/dram_pd_countdown.sv
// Saturating down-counter. A load of N makes done true after N cycles (at least one).
module dram_pd_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? '0 : load_val - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/dram_pd_read_tail.sv
// Tracks the read burst tail: busy from the read command until AL+CL+BL/2 clocks later.
module dram_pd_read_tail #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_cmd,
    input  logic [LAT_W-1:0] cfg_al,
    input  logic [LAT_W-1:0] cfg_cl,
    input  logic             cfg_bl8,
    output logic             tail_busy
);
    localparam int CNT_W = LAT_W + 2;

    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] span;

    always_comb begin
        span = CNT_W'(cfg_al) + CNT_W'(cfg_cl) + (cfg_bl8 ? CNT_W'(4) : CNT_W'(2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (rd_cmd) begin
            left_q <= span;
        end else if (left_q != '0) begin
            left_q <= left_q - CNT_W'(1);
        end
    end

    assign tail_busy = rd_cmd | (left_q != '0);

    // R4: a read always leaves the tail busy in the following cycle.
    p_tail_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |=> tail_busy);

endmodule

// File: rtl/dram_pd_residency.sv
// Counts cycles spent with clock-enable low and flags the 9 x tREFI cap.
module dram_pd_residency #(
    parameter int TREFI_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               run,
    input  logic [TREFI_W-1:0] cfg_trefi,
    output logic [TREFI_W+3:0] res_cnt,
    output logic               limit_hit
);
    localparam int RES_W = TREFI_W + 4;

    logic [RES_W-1:0] limit;
    logic [RES_W-1:0] cnt_q;

    always_comb begin
        limit = (RES_W'(cfg_trefi) << 3) + RES_W'(cfg_trefi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != '1)) begin
            cnt_q <= cnt_q + RES_W'(1);
        end
    end

    // The cycle holding count limit-1 is the last one allowed low.
    assign limit_hit = ({1'b0, cnt_q} + (RES_W+1)'(1)) >= {1'b0, limit};
    assign res_cnt   = cnt_q;

    // R9: the low-time counter never reaches the cap while running.
    p_residency_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && limit != '0) |-> (cnt_q < limit));

endmodule

// File: rtl/dram_pd_ctrl.sv
module dram_pd_ctrl
    import dram_pd_pkg::*;
#(
    parameter int NBANK   = 8,
    parameter int LAT_W   = 4,
    parameter int TW      = 8,
    parameter int TREFI_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_req,
    input  logic [NBANK-1:0]   bank_open,
    input  logic               mrs_busy,
    input  logic               wr_busy,
    input  logic               rd_cmd,
    input  logic [LAT_W-1:0]   cfg_al,
    input  logic [LAT_W-1:0]   cfg_cl,
    input  logic               cfg_bl8,
    input  logic               cfg_fast_exit,
    input  logic [TW-1:0]      cfg_tcke,
    input  logic [TW-1:0]      cfg_txp,
    input  logic [TW-1:0]      cfg_txard,
    input  logic [TW-1:0]      cfg_txards,
    input  logic [TREFI_W-1:0] cfg_trefi,
    output logic               cke,
    output logic               cmd_inhibit,
    output logic               force_nop,
    output logic [1:0]         pd_mode
);
    localparam int RES_W = TREFI_W + 4;

    pd_state_e         state_q, state_d;
    pd_mode_e          mode_q;
    logic              wake_q;
    logic              refhold_q;
    logic              tail_busy;
    logic              blocked;
    logic              exit_req;
    logic              enter_go;
    logic              exit_go;
    logic              hold_done;
    logic              lat_done;
    logic              low_run;
    logic              limit_hit;
    logic [RES_W-1:0]  res_cnt;
    logic [TW-1:0]     exit_lat;

    dram_pd_read_tail #(.LAT_W(LAT_W)) u_tail (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_cmd    (rd_cmd),
        .cfg_al    (cfg_al),
        .cfg_cl    (cfg_cl),
        .cfg_bl8   (cfg_bl8),
        .tail_busy (tail_busy)
    );

    dram_pd_residency #(.TREFI_W(TREFI_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (enter_go),
        .run       (low_run),
        .cfg_trefi (cfg_trefi),
        .res_cnt   (res_cnt),
        .limit_hit (limit_hit)
    );

    // Minimum pulse width timer, shared by the low hold and the high hold.
    dram_pd_countdown #(.W(TW)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (enter_go | exit_go),
        .load_val (cfg_tcke),
        .done     (hold_done)
    );

    // Exit latency timer, started on the rising clock-enable edge.
    dram_pd_countdown #(.W(TW)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (exit_go),
        .load_val (exit_lat),
        .done     (lat_done)
    );

    always_comb begin
        unique case (mode_q)
            PDM_PRECHARGE: exit_lat = cfg_txp;
            PDM_ACT_FAST:  exit_lat = cfg_txard;
            PDM_ACT_SLOW:  exit_lat = cfg_txards;
            default:       exit_lat = cfg_txp;
        endcase
    end

    assign blocked  = mrs_busy | wr_busy;
    assign exit_req = ~pd_req | wake_q | limit_hit;
    assign low_run  = (state_q == ST_PD_ENTER_HOLD) || (state_q == ST_POWER_DOWN);
    assign enter_go = (state_d == ST_PD_ENTER_HOLD) && (state_q != ST_PD_ENTER_HOLD);
    assign exit_go  = (state_d == ST_PD_EXIT_HOLD)  && (state_q != ST_PD_EXIT_HOLD);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (pd_req && !refhold_q && !blocked) begin
                    state_d = tail_busy ? ST_WAIT_BURST_END : ST_PD_ENTER_HOLD;
                end
            end
            ST_WAIT_BURST_END: begin
                if (!pd_req) begin
                    state_d = ST_ACTIVE;
                end else if (!blocked && !tail_busy) begin
                    state_d = ST_PD_ENTER_HOLD;
                end
            end
            ST_PD_ENTER_HOLD: begin
                if (hold_done) begin
                    state_d = exit_req ? ST_PD_EXIT_HOLD : ST_POWER_DOWN;
                end
            end
            ST_POWER_DOWN: begin
                if (exit_req) begin
                    state_d = ST_PD_EXIT_HOLD;
                end
            end
            ST_PD_EXIT_HOLD: begin
                if (hold_done) begin
                    state_d = lat_done ? ST_ACTIVE : ST_EXIT_LATENCY;
                end
            end
            ST_EXIT_LATENCY: begin
                if (lat_done) begin
                    state_d = ST_ACTIVE;
                end
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    // State register and entry bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_ACTIVE;
            mode_q    <= PDM_NONE;
            wake_q    <= 1'b0;
            refhold_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (enter_go) begin
                mode_q <= pick_mode(|bank_open, cfg_fast_exit);
            end
            if (enter_go) begin
                wake_q <= 1'b0;
            end else if (state_q == ST_PD_ENTER_HOLD && !pd_req) begin
                wake_q <= 1'b1;
            end
            if (exit_go && limit_hit) begin
                refhold_q <= 1'b1;
            end else if (!pd_req) begin
                refhold_q <= 1'b0;
            end
        end
    end

    // Outputs, decoded from the registered state only.
    always_comb begin
        cke         = 1'b1;
        cmd_inhibit = 1'b0;
        force_nop   = 1'b0;
        pd_mode     = PDM_NONE;
        unique case (state_q)
            ST_ACTIVE, ST_WAIT_BURST_END: begin
            end
            ST_PD_ENTER_HOLD, ST_POWER_DOWN: begin
                cke         = 1'b0;
                cmd_inhibit = 1'b1;
                force_nop   = 1'b1;
                pd_mode     = mode_q;
            end
            ST_PD_EXIT_HOLD: begin
                cmd_inhibit = 1'b1;
                force_nop   = 1'b1;
            end
            ST_EXIT_LATENCY: begin
                cmd_inhibit = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // R3: clock-enable only falls when no mode-register or write activity preceded it.
    p_no_entry_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(!mrs_busy && !wr_busy));

    // R4: clock-enable only falls once the read tail has cleared.
    p_no_entry_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> !$past(tail_busy));

    // R5: an all-idle bank set at entry gives precharge power-down.
    p_precharge_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cke) && $past(bank_open == '0)) |-> (pd_mode == 2'b01));

    // R6: the low pulse lasted at least the minimum width.
    p_min_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (int'($past(res_cnt)) + 1 >= int'(cfg_tcke)));

    // R7 / R8: the rising edge carries a forced NOP and a gated command path.
    p_exit_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (force_nop && cmd_inhibit));

    // R10: after a forced exit no entry happens while the lockout is set.
    p_refresh_lockout_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && refhold_q) |=> cke);

endmodule

// File: tb/dram_pd_ctrl_bench.sv
module dram_pd_ctrl_bench;

    localparam int NBANK = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_req = 1'b0;
    logic [7:0] bank_open = '0;
    logic       mrs_busy = 1'b0;
    logic       wr_busy = 1'b0;
    logic       rd_cmd = 1'b0;
    logic [3:0] cfg_al = 4'd1;
    logic [3:0] cfg_cl = 4'd3;
    logic       cfg_bl8 = 1'b0;
    logic       cfg_fast_exit = 1'b1;
    logic [7:0] cfg_tcke = 8'd3;
    logic [7:0] cfg_txp = 8'd2;
    logic [7:0] cfg_txard = 8'd4;
    logic [7:0] cfg_txards = 8'd7;
    logic [15:0] cfg_trefi = 16'd20;
    logic       cke, cmd_inhibit, force_nop;
    logic [1:0] pd_mode;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    compare_on = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;   // 125 MHz

    dram_pd_ctrl #(.NBANK(NBANK)) u_dram_pd_ctrl (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .bank_open(bank_open),
        .mrs_busy(mrs_busy), .wr_busy(wr_busy), .rd_cmd(rd_cmd),
        .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
        .cfg_fast_exit(cfg_fast_exit), .cfg_tcke(cfg_tcke), .cfg_txp(cfg_txp),
        .cfg_txard(cfg_txard), .cfg_txards(cfg_txards), .cfg_trefi(cfg_trefi),
        .cke(cke), .cmd_inhibit(cmd_inhibit), .force_nop(force_nop), .pd_mode(pd_mode)
    );

    // Behavioural reference: phase 0 run, 1 drain, 2 low-hold, 3 rest, 4 high-hold, 5 latency.
    int m_ph, m_lo, m_hi, m_lat, m_rdleft, m_mode;
    bit m_wake, m_ref;
    int t_span, t_lim;
    bit t_rbusy, t_blk, t_setref;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_lo = 0; m_hi = 0; m_lat = 0; m_rdleft = 0; m_mode = 0;
            m_wake = 0; m_ref = 0;
        end else begin
            t_span   = int'(cfg_al) + int'(cfg_cl) + (cfg_bl8 ? 4 : 2);
            t_rbusy  = rd_cmd || (m_rdleft > 0);
            t_blk    = mrs_busy || wr_busy;
            t_lim    = 9 * int'(cfg_trefi);
            t_setref = 0;
            m_rdleft = rd_cmd ? t_span : ((m_rdleft > 0) ? m_rdleft - 1 : 0);
            case (m_ph)
                0, 1: begin
                    if (m_ph == 1 && !pd_req) m_ph = 0;
                    else if (pd_req && (m_ph == 1 || !m_ref) && !t_blk) begin
                        if (t_rbusy) m_ph = 1;
                        else begin
                            m_ph = 2; m_lo = 1; m_wake = 0;
                            m_mode = (bank_open == '0) ? 1 : (cfg_fast_exit ? 2 : 3);
                        end
                    end
                end
                2, 3: begin
                    if (m_ph == 2 && !pd_req) m_wake = 1;
                    if (m_ph == 2 && m_lo < int'(cfg_tcke)) m_lo++;
                    else if (m_wake || !pd_req || m_lo >= t_lim) begin
                        t_setref = (m_lo >= t_lim);
                        m_ph = 4; m_hi = 1;
                        m_lat = (m_mode == 1) ? int'(cfg_txp) :
                                (m_mode == 2) ? int'(cfg_txard) : int'(cfg_txards);
                    end else begin
                        m_ph = 3; m_lo++;
                    end
                end
                4: begin
                    if (m_hi < int'(cfg_tcke)) m_hi++;
                    else if (m_hi >= m_lat) m_ph = 0;
                    else begin m_ph = 5; m_hi++; end
                end
                default: begin
                    if (m_hi >= m_lat) m_ph = 0;
                    else m_hi++;
                end
            endcase
            if (t_setref) m_ref = 1;
            else if (!pd_req) m_ref = 0;
        end
    end

    task automatic chk(input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (compare_on) begin
            chk("cke",         int'(cke),         (m_ph == 2 || m_ph == 3) ? 0 : 1);
            chk("cmd_inhibit", int'(cmd_inhibit), (m_ph >= 2) ? 1 : 0);
            chk("force_nop",   int'(force_nop),   (m_ph >= 2 && m_ph <= 4) ? 1 : 0);
            chk("pd_mode",     int'(pd_mode),     (m_ph == 2 || m_ph == 3) ? m_mode : 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL %s watchdog: actual hung expected finished", cur_req);
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset values, checked explicitly
        cur_req = "R1";
        chk("reset cke", int'(cke), 1);
        chk("reset cmd_inhibit", int'(cmd_inhibit), 0);
        chk("reset force_nop", int'(force_nop), 0);
        chk("reset pd_mode", int'(pd_mode), 0);
        compare_on = 1'b1;
        cyc(2);

        // R2, R5, R7, R8: precharge entry, exit latency shorter than tCKE
        cur_req = "R2";
        bank_open = '0; pd_req = 1'b1; cyc(10);
        cur_req = "R7"; pd_req = 1'b0; cyc(12);

        // R5, R8: active fast exit then slow exit
        cur_req = "R5";
        bank_open = 8'h02; cfg_fast_exit = 1'b1; pd_req = 1'b1; cyc(9);
        cur_req = "R8"; pd_req = 1'b0; cyc(12);
        cur_req = "R5";
        cfg_fast_exit = 1'b0; pd_req = 1'b1; cyc(9);
        cur_req = "R8"; pd_req = 1'b0; cyc(14);

        // R3: busy flags block entry
        cur_req = "R3";
        bank_open = '0; mrs_busy = 1'b1; pd_req = 1'b1; cyc(8);
        mrs_busy = 1'b0; wr_busy = 1'b1; cyc(8);
        pd_req = 1'b0; wr_busy = 1'b0; cyc(4);

        // R4: read tail with both burst lengths
        cur_req = "R4";
        cfg_bl8 = 1'b1; rd_cmd = 1'b1; cyc(1); rd_cmd = 1'b0; pd_req = 1'b1; cyc(16);
        pd_req = 1'b0; cyc(10);
        cfg_bl8 = 1'b0; rd_cmd = 1'b1; pd_req = 1'b1; cyc(1); rd_cmd = 1'b0; cyc(14);
        pd_req = 1'b0; cyc(10);

        // R11: request withdrawn while the tail drains
        cur_req = "R11";
        rd_cmd = 1'b1; cyc(1); rd_cmd = 1'b0; pd_req = 1'b1; cyc(3);
        pd_req = 1'b0; cyc(12);

        // R6: one-cycle request, wake pending during the low hold
        cur_req = "R6";
        cfg_tcke = 8'd5; pd_req = 1'b1; cyc(1); pd_req = 1'b0; cyc(16);
        pd_req = 1'b1; cyc(2); pd_req = 1'b0; cyc(1); pd_req = 1'b1; cyc(8);
        pd_req = 1'b0; cyc(14);
        cfg_tcke = 8'd3;

        // R9, R10: residency cap and lockout
        cur_req = "R9";
        bank_open = 8'h80; cfg_fast_exit = 1'b1; pd_req = 1'b1; cyc(190);
        cur_req = "R10"; cyc(20);
        pd_req = 1'b0; cyc(2); pd_req = 1'b1; cyc(10);
        pd_req = 1'b0; cyc(12);

        finish_run();
    end

endmodule